// File: doc/BRIEF.md
# System Control Port with Refresh Toggle

This block is a byte-wide control and status register that sits beside the third channel of an interval timer. A write to it sets that channel's gate input and a speaker data enable. A read returns a status byte that holds both of those settings, a refresh toggle that runs freely, and the live output of the third channel. The refresh toggle is produced by a prescaler on the system clock. Its half period is set in nanoseconds and defaults to 16384 ns, which approximates a refresh strobe of about 15 us.

The gate register drives the timer channel directly. A write reaches `gate2_o` on the clock edge that accepts it, so the timer sees a clean, synchronous level change and can detect a rising edge. The speaker output is the AND of the speaker enable and the channel output. Read data is captured on the edge that accepts a read strobe and then held until the next read.

Top module: `sys_ctrl_port`

## Requirements
- R1: While `rst_ni` is low, `gate2_o`, `spk_en_o`, `rd_data_o` and the refresh toggle are all 0.
- R2: A write (`wr_en_i` high at a rising edge) sets `gate2_o` to `wr_data_i[0]` from that edge onward.
- R3: A write sets `spk_en_o` to `wr_data_i[1]` from that edge onward.
- R4: Write data bits 7..2 have no effect: they never reach any output or any read-back bit.
- R5: A read (`rd_en_i` high at a rising edge) loads `rd_data_o` with this layout: bit 0 = gate, bit 1 = speaker enable, bit 4 = refresh toggle, bit 5 = `out2_i` as sampled at that edge, and bits 7, 6, 3 and 2 = 0. Without a read, `rd_data_o` holds its value.
- R6: The refresh toggle starts at 0 after reset. It inverts after every DIV rising edges, where DIV = TOGGLE_NS / CLK_PERIOD_NS.
- R7: `spk_o` is always `spk_en_o` AND `out2_i`.
- R8: When a read and a write happen on the same edge, the read returns the gate and enable values from before the write.
- R9: With no write, `gate2_o` and `spk_en_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Status byte from the last read |
| out2_i | input | 1 | Output of timer channel 2 |
| gate2_o | output | 1 | Gate input of timer channel 2 |
| spk_en_o | output | 1 | Speaker data enable |
| spk_o | output | 1 | Gated speaker drive |

## Verification
The bench sets CLK_PERIOD_NS to 4 and TOGGLE_NS to 64, which gives DIV = 16. With that setting the refresh toggle inverts dozens of times within a few thousand cycles, and random reads sample both phases and the edges where the toggle changes. The default DIV of 4096 would allow only a handful of toggles in the same run. Write data carries random upper bits, reads and writes often fall on the same edge, and `out2_i` changes at random, so that the ignored bits, the read-before-write order and the AND on the speaker output are all exercised.

// File: rtl/sys_ctrl_port_pkg.sv
package sys_ctrl_port_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned GATE_BIT  = 0;
  localparam int unsigned SPKEN_BIT = 1;
  localparam int unsigned REFR_BIT  = 4;
  localparam int unsigned OUT2_BIT  = 5;

  typedef struct packed {
    logic spk_en;
    logic gate;
  } ctrl_state_t;
endpackage

// File: rtl/refresh_prescaler.sv
module refresh_prescaler #(
  parameter int unsigned DIV = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tog_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tog_o = tog_q;

  initial assert (DIV >= 2) else $error("prescaler DIV must be at least 2");

  p_toggle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(tog_q));
  p_toggle_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import sys_ctrl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output ctrl_state_t       state_o
);
  ctrl_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (wr_en_i) begin
      state_q.gate   <= wr_data_i[GATE_BIT];
      state_q.spk_en <= wr_data_i[SPKEN_BIT];
    end
  end

  assign state_o = state_q;

  p_write_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (state_o.gate == $past(wr_data_i[GATE_BIT])));
  p_write_spken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (state_o.spk_en == $past(wr_data_i[SPKEN_BIT])));
  p_hold_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_o));
endmodule

// File: rtl/status_read.sv
module status_read
  import sys_ctrl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  ctrl_state_t       state_i,
  input  logic              refr_i,
  input  logic              out2_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] status_d;
  logic [BYTE_W-1:0] rd_q;

  always_comb begin
    status_d            = '0;
    status_d[GATE_BIT]  = state_i.gate;
    status_d[SPKEN_BIT] = state_i.spk_en;
    status_d[REFR_BIT]  = refr_i;
    status_d[OUT2_BIT]  = out2_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= status_d;
  end

  assign rd_data_o = rd_q;

  p_read_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  p_read_out2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o[OUT2_BIT] == $past(out2_i)));
  p_read_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o[GATE_BIT] == $past(state_i.gate)));
endmodule

// File: rtl/sys_ctrl_port.sv
module sys_ctrl_port
  import sys_ctrl_port_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned TOGGLE_NS     = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              out2_i,
  output logic              gate2_o,
  output logic              spk_en_o,
  output logic              spk_o
);
  localparam int unsigned DIV = TOGGLE_NS / CLK_PERIOD_NS;

  ctrl_state_t state;
  logic        refr;

  refresh_prescaler #(.DIV(DIV)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tog_o (refr)
  );

  ctrl_reg i_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .state_o  (state)
  );

  status_read i_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .state_i  (state),
    .refr_i   (refr),
    .out2_i   (out2_i),
    .rd_data_o(rd_data_o)
  );

  assign gate2_o  = state.gate;
  assign spk_en_o = state.spk_en;
  assign spk_o    = state.spk_en & out2_i;

  p_unused_bits_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7:6] == 2'b00) && (rd_data_o[3:2] == 2'b00));
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!gate2_o && !spk_en_o && rd_data_o == '0));
endmodule

// File: tb/test_sys_ctrl_port.sv
module test_sys_ctrl_port;
  localparam int CLK_NS = 4;
  localparam int TOG_NS = 64;
  localparam int DIV    = TOG_NS / CLK_NS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, out2 = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       gate2, spk_en, spk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit         m_gate, m_en, m_tog, m_both;
  bit [7:0]   m_rd;
  int         m_cnt;

  always #(CLK_NS/2) clk = ~clk;

  sys_ctrl_port #(.CLK_PERIOD_NS(CLK_NS), .TOGGLE_NS(TOG_NS)) i_sys_ctrl_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .out2_i(out2),
    .gate2_o(gate2), .spk_en_o(spk_en), .spk_o(spk)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate = 0; m_en = 0; m_tog = 0; m_rd = '0; m_cnt = 0; m_both = 0;
    end else begin
      m_both = rd_en && wr_en;
      if (rd_en) m_rd = {2'b00, out2, m_tog, 2'b00, m_en, m_gate};
      if (wr_en) begin m_gate = wr_data[0]; m_en = wr_data[1]; end
      m_cnt++;
      if (m_cnt == DIV) begin m_cnt = 0; m_tog = ~m_tog; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 gate", gate2, m_gate);
    chk("R3 spk_en", spk_en, m_en);
    chk("R7 spk", spk, m_en & out2);
    if (rd_data[4] != m_rd[4]) chk("R6 refresh", rd_data, m_rd);
    else if (m_both) chk("R8 read-before-write", rd_data, m_rd);
    else chk("R5 read layout", rd_data, m_rd);
    chk("R4 unused bits", {rd_data[7:6], rd_data[3:2]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gate", gate2, 0);
    chk("R1 spk_en", spk_en, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    // directed: write with upper bits set, then read
    @(negedge clk); compare_all();
    wr_en = 1; wr_data = 8'hFD; @(negedge clk); compare_all();      // gate=1, en=0
    wr_en = 0; rd_en = 1; out2 = 1; @(negedge clk); compare_all();
    rd_en = 0; repeat (5) begin @(negedge clk); compare_all(); end  // R9 hold
    wr_en = 1; rd_en = 1; wr_data = 8'h02; @(negedge clk); compare_all(); // R8
    wr_en = 0; rd_en = 0;
    // first refresh toggle seen via back-to-back reads
    rd_en = 1;
    repeat (2*DIV) begin @(negedge clk); compare_all(); end
    rd_en = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      wr_en   = ($urandom_range(0, 3) == 0);
      rd_en   = ($urandom_range(0, 1) == 0);
      wr_data = 8'($urandom);
      out2    = ($urandom_range(0, 2) == 0) ? ~out2 : out2;
    end
    @(negedge clk); compare_all();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule